// File: doc/BRIEF.md
# Sprite Memory Copy Engine with CPU Bus Lockout

This block copies a 160-byte page from the CPU address space into sprite attribute memory, one byte per transfer slot. Software starts it by writing a page number, which gives the high byte of the source address. The engine then issues its own read strobe toward the memory arbiter. On the same cycle it issues a write strobe into sprite memory, and the byte read comes back combinationally from the arbiter.

While the copy is in flight, the engine also filters CPU traffic. The CPU address is compared against a lockout window and against sprite memory. A CPU read that falls inside either area returns 0xFF without reaching the bus. A CPU write that falls inside either area is dropped. The lockout window depends on two things: the 8 KiB bus region that the source page lies in, and a hardware model (monochrome or colour) that is captured at reset.

The copy runs at a fixed cadence set by the engine, so the transfer port has no ready and no back-pressure. The arbiter must serve a read strobe in the same cycle. The CPU side passes through combinationally.

Top module: `oamdma_engine`

## Requirements
- R1: After reset, `busy`, `conflict`, `src_rd` and `oam_we` are low, and CPU reads and writes pass through to the bus unchanged.
- R2: A start write whose page is above 0xF1 (source above 0xF100) is ignored. It starts nothing when idle and leaves a running copy undisturbed.
- R3: A copy moves exactly 160 bytes. Byte k is read from source address page*256+k and written to sprite index k with the data read in that same cycle.
- R4: The strobe for the first byte is high in the 8th cycle after the clock edge that accepts the start, so its write completes 8 edges after the start. Each later strobe follows 4 cycles after the previous one.
- R5: `busy` rises on the edge that accepts a start. It stays high through the last byte's strobe cycle and falls on the edge that completes that write.
- R6: While busy, CPU accesses to 0xFE00–0xFE9F are blocked: reads return 0xFF with no bus read, and writes are dropped.
- R7: On the monochrome model (model input 0 at reset), source address bits [15:13] = 4 lock 0x8000–0x9FFF. Any other value locks 0xA000–0xFDFF.
- R8: On the colour model (model input 1 at reset), source region 4 locks 0x8000–0x9FFF, region 6 locks 0xC000–0xFDFF, and any other region locks 0xA000–0xBFFF.
- R9: The model input is sampled only while reset is asserted. Changing it afterwards has no effect on the lockout window.
- R10: A valid start during a running copy restarts from the new page with the full count. The timing is the same as a fresh start.
- R11: When not busy, no address is blocked and `conflict` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; model is captured while high |
| model_sel | input | 1 | 0 = monochrome lockout table, 1 = colour table |
| cfg_wr | input | 1 | Start request strobe |
| cfg_page | input | 8 | Source page (high address byte) |
| busy | output | 1 | Copy in progress |
| src_rd | output | 1 | Source read strobe toward the arbiter |
| src_addr | output | 16 | Source read address |
| src_rdata | input | 8 | Source read data, valid in the strobe cycle |
| oam_we | output | 1 | Sprite memory write strobe |
| oam_waddr | output | 8 | Sprite memory byte index |
| oam_wdata | output | 8 | Sprite memory write data |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| bus_addr | output | 16 | Address forwarded to the bus |
| bus_rd | output | 1 | Forwarded read request (gated) |
| bus_wr | output | 1 | Forwarded write request (gated) |
| bus_wdata | output | 8 | Forwarded write data |
| bus_rdata | input | 8 | Bus read data |
| conflict | output | 1 | Current CPU address is locked out |

## Verification
The bench checks the edges of each lockout window on both models. These include 0x9FFF against 0xA000, 0xBFFF against 0xC000, 0xFDFF, 0xFE9F against 0xFEA0, and a page of exactly 0xF1. A design with an off-by-one bound, or with the two tables swapped, would either return bus data where 0xFF is due or block a legal address. The bench times every strobe of full copies, so a wrong first delay or slot gap shows as a cycle mismatch on every byte. It also restarts a copy mid-flight, where a design that keeps the old count or old source would write the wrong number of bytes or the wrong data. It changes the model input after reset; a design that follows the live input would pick the other table. Finally, it issues an out-of-range start both idle and mid-copy; a design that accepts it would raise `busy` or reset the byte index.

// File: rtl/oamdma_pkg.sv
package oamdma_pkg;

  typedef enum logic {
    MODEL_MONO  = 1'b0,
    MODEL_COLOR = 1'b1
  } model_e;

  // half-open address span [lo, hi)
  typedef struct packed {
    logic [15:0] lo;
    logic [15:0] hi;
  } span_t;

  localparam logic [15:0] VID_LO  = 16'h8000;
  localparam logic [15:0] EXT_LO  = 16'hA000;
  localparam logic [15:0] WORK_LO = 16'hC000;
  localparam logic [15:0] ECHO_HI = 16'hFE00;

  // lockout span selected by source region (addr[15:13]) and model
  function automatic span_t lock_span(model_e m, logic [2:0] region);
    span_t s;
    if (region == 3'd4) begin
      s.lo = VID_LO;
      s.hi = EXT_LO;
    end else if (m == MODEL_MONO) begin
      s.lo = EXT_LO;
      s.hi = ECHO_HI;
    end else if (region == 3'd6) begin
      s.lo = WORK_LO;
      s.hi = ECHO_HI;
    end else begin
      s.lo = EXT_LO;
      s.hi = WORK_LO;
    end
    return s;
  endfunction

endpackage

// File: rtl/oamdma_window.sv
module oamdma_window
  import oamdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        model_sel,
  input  logic        load,
  input  logic [2:0]  region,
  output logic [15:0] lock_lo,
  output logic [15:0] lock_hi
);

  model_e model_q;
  span_t  span_q;
  span_t  span_next;

  always_ff @(posedge clk) begin
    if (rst) model_q <= model_e'(model_sel);
  end

  always_comb span_next = lock_span(model_q, region);

  always_ff @(posedge clk) begin
    if (rst) begin
      span_q <= '0;
    end else if (load) begin
      span_q <= span_next;
    end
  end

  assign lock_lo = span_q.lo;
  assign lock_hi = span_q.hi;

endmodule

// File: rtl/oamdma_seq.sv
module oamdma_seq #(
  parameter int           XFER_LEN    = 160,
  parameter int           FIRST_DELAY = 8,
  parameter int           SLOT_GAP    = 4,
  parameter logic [7:0]   PAGE_MAX    = 8'hF1,
  localparam int          CNT_W  = $clog2(XFER_LEN + 1),
  localparam int          IDX_W  = $clog2(XFER_LEN),
  localparam int          WMAX   = (FIRST_DELAY > SLOT_GAP) ? FIRST_DELAY : SLOT_GAP,
  localparam int          WAIT_W = $clog2(WMAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_page,
  output logic             start,
  output logic             busy,
  output logic             xfer,
  output logic [15:0]      src_addr,
  output logic [IDX_W-1:0] dst_idx
);

  logic [CNT_W-1:0]  remain_q;
  logic [WAIT_W-1:0] wait_q;
  logic [15:0]       src_q;
  logic [IDX_W-1:0]  dst_q;

  assign start = cfg_wr && (cfg_page <= PAGE_MAX);
  assign busy  = (remain_q != '0);
  assign xfer  = busy && (wait_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      wait_q   <= '0;
      src_q    <= '0;
      dst_q    <= '0;
    end else if (start) begin
      remain_q <= CNT_W'(XFER_LEN);
      wait_q   <= WAIT_W'(FIRST_DELAY - 1);
      src_q    <= {cfg_page, 8'h00};
      dst_q    <= '0;
    end else if (busy) begin
      if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else begin
        remain_q <= remain_q - 1'b1;
        wait_q   <= WAIT_W'(SLOT_GAP - 1);
        src_q    <= src_q + 16'd1;
        dst_q    <= dst_q + 1'b1;
      end
    end
  end

  assign src_addr = src_q;
  assign dst_idx  = dst_q;

endmodule

// File: rtl/oamdma_gate.sv
module oamdma_gate #(
  parameter logic [15:0] SPR_BASE = 16'hFE00,
  parameter int          SPR_LEN  = 160,
  localparam logic [16:0] SPR_END = {1'b0, SPR_BASE} + 17'(SPR_LEN)
) (
  input  logic        busy,
  input  logic [15:0] lock_lo,
  input  logic [15:0] lock_hi,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        conflict
);

  logic in_spr;
  logic in_span;

  always_comb begin
    in_spr  = (cpu_addr >= SPR_BASE) && ({1'b0, cpu_addr} < SPR_END);
    in_span = (cpu_addr >= lock_lo) && (cpu_addr < lock_hi);
  end

  assign conflict  = busy && (in_spr || in_span);
  assign bus_addr  = cpu_addr;
  assign bus_wdata = cpu_wdata;
  assign bus_rd    = cpu_rd && !conflict;
  assign bus_wr    = cpu_wr && !conflict;
  assign cpu_rdata = conflict ? 8'hFF : bus_rdata;

endmodule

// File: rtl/oamdma_engine.sv
module oamdma_engine #(
  parameter int          XFER_LEN    = 160,
  parameter int          FIRST_DELAY = 8,
  parameter int          SLOT_GAP    = 4,
  parameter logic [7:0]  PAGE_MAX    = 8'hF1,
  parameter logic [15:0] SPR_BASE    = 16'hFE00,
  localparam int         IDX_W       = $clog2(XFER_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             model_sel,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_page,
  output logic             busy,
  output logic             src_rd,
  output logic [15:0]      src_addr,
  input  logic [7:0]       src_rdata,
  output logic             oam_we,
  output logic [IDX_W-1:0] oam_waddr,
  output logic [7:0]       oam_wdata,
  input  logic [15:0]      cpu_addr,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic [15:0]      bus_addr,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             conflict
);

  logic        start;
  logic        xfer;
  logic [15:0] lock_lo;
  logic [15:0] lock_hi;

  oamdma_seq #(
    .XFER_LEN(XFER_LEN), .FIRST_DELAY(FIRST_DELAY),
    .SLOT_GAP(SLOT_GAP), .PAGE_MAX(PAGE_MAX)
  ) u_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_page(cfg_page),
    .start(start), .busy(busy), .xfer(xfer),
    .src_addr(src_addr), .dst_idx(oam_waddr)
  );

  oamdma_window u_win (
    .clk(clk), .rst(rst), .model_sel(model_sel), .load(start),
    .region(cfg_page[7:5]), .lock_lo(lock_lo), .lock_hi(lock_hi)
  );

  oamdma_gate #(.SPR_BASE(SPR_BASE), .SPR_LEN(XFER_LEN)) u_gate (
    .busy(busy), .lock_lo(lock_lo), .lock_hi(lock_hi),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conflict(conflict)
  );

  assign src_rd    = xfer;
  assign oam_we    = xfer;
  assign oam_wdata = src_rdata;

endmodule

// File: rtl/oamdma_engine_chk.sv
module oamdma_engine_chk #(
  parameter logic [7:0]  PAGE_MAX = 8'hF1,
  parameter logic [15:0] SPR_BASE = 16'hFE00,
  parameter int          SPR_LEN  = 160
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic [7:0]  cfg_page,
  input logic        busy,
  input logic        src_rd,
  input logic        oam_we,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        conflict
);

  logic in_spr;
  assign in_spr = (cpu_addr >= SPR_BASE) && ({1'b0, cpu_addr} < ({1'b0, SPR_BASE} + 17'(SPR_LEN)));

  // R1
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!oam_we && !src_rd));

  // R3
  paired_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    oam_we |-> src_rd);

  // R4
  slot_gap_chk: assert property (@(posedge clk) disable iff (rst)
    oam_we |=> !oam_we);

  // R2
  bad_page_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && cfg_wr && (cfg_page > PAGE_MAX)) |=> !busy);

  // R10
  good_page_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_page <= PAGE_MAX)) |=> busy);

  // R6
  spr_read_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_rd && in_spr) |-> (cpu_rdata == 8'hFF && !bus_rd && conflict));

  // R6
  spr_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_wr && in_spr) |-> !bus_wr);

  // R11
  idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!conflict && (bus_rd == cpu_rd) && (bus_wr == cpu_wr)));

endmodule

bind oamdma_engine oamdma_engine_chk #(
  .PAGE_MAX(PAGE_MAX), .SPR_BASE(SPR_BASE), .SPR_LEN(XFER_LEN)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_page(cfg_page),
  .busy(busy), .src_rd(src_rd), .oam_we(oam_we),
  .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_rdata(cpu_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .conflict(conflict)
);

// File: tb/oamdma_engine_test.sv
module oamdma_engine_test;

  localparam int LEN = 160;
  localparam logic [7:0] BUS_VAL = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        model_sel = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_page = 8'h00;
  logic        busy, src_rd, oam_we, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [15:0] src_addr, cpu_addr = 16'h0000, bus_addr;
  logic [7:0]  src_rdata, oam_waddr, oam_wdata, cpu_wdata = 8'h00, cpu_rdata, bus_wdata;
  logic        bus_rd, bus_wr, conflict;
  logic [7:0]  bus_rdata = BUS_VAL;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  bit mon_on = 1'b0;
  int mon_t0 = 0;
  int mon_k  = 0;
  logic [15:0] mon_base = 16'h0000;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] src_pat(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign src_rdata = src_pat(src_addr);

  oamdma_engine uut (
    .clk(clk), .rst(rst), .model_sel(model_sel), .cfg_wr(cfg_wr), .cfg_page(cfg_page),
    .busy(busy), .src_rd(src_rd), .src_addr(src_addr), .src_rdata(src_rdata),
    .oam_we(oam_we), .oam_waddr(oam_waddr), .oam_wdata(oam_wdata),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conflict(conflict)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every strobe checked for timing, index, source and data
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (oam_we) begin
      if (!mon_on) begin
        chk(1'b0, "R2 unexpected strobe", 1, 0);
      end else begin
        chk(cyc == mon_t0 + 8 + 4 * mon_k, "R4 strobe cycle", cyc - mon_t0, 8 + 4 * mon_k);
        chk(oam_waddr == mon_k[7:0], "R3 dest index", oam_waddr, mon_k);
        chk(src_addr == mon_base + 16'(mon_k), "R3 source addr", src_addr, mon_base + 16'(mon_k));
        chk(oam_wdata == src_pat(src_addr), "R3 data", oam_wdata, src_pat(src_addr));
        chk(busy == 1'b1, "R5 busy during copy", busy, 1);
        mon_k = mon_k + 1;
        if (mon_k == LEN) mon_on = 1'b0;
      end
    end
  end

  task automatic do_reset(input logic m);
    @(negedge clk); #1;
    rst = 1'b1; model_sel = m; mon_on = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic start_xfer(input logic [7:0] pg, input bit accept);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_page = pg;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    if (accept) begin
      mon_t0 = cyc; mon_k = 0; mon_base = {pg, 8'h00}; mon_on = 1'b1;
      chk(busy == 1'b1, "R5 busy after start", busy, 1);
    end
  endtask

  task automatic probe(input logic [15:0] a, input bit blk, input string req);
    @(negedge clk); #1;
    cpu_addr = a; cpu_rd = 1'b1; #1;
    chk(cpu_rdata == (blk ? 8'hFF : BUS_VAL), req, cpu_rdata, blk ? 8'hFF : BUS_VAL);
    chk(conflict == blk, req, conflict, blk);
    cpu_rd = 1'b0; cpu_wr = 1'b1; #1;
    chk(bus_wr == !blk, req, bus_wr, !blk);
    cpu_wr = 1'b0;
  endtask

  task automatic wait_done();
    wait (mon_k == LEN);
    @(negedge clk); #1;
    chk(busy == 1'b0, "R5 busy falls after last byte", busy, 0);
  endtask

  // {model, page, probe address, blocked}
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h00, 16'hA000, 1'b1}, {1'b0, 8'h00, 16'h9FFF, 1'b0},
    {1'b0, 8'h00, 16'hFDFF, 1'b1}, {1'b0, 8'h00, 16'hFE9F, 1'b1},
    {1'b0, 8'h00, 16'hFEA0, 1'b0}, {1'b0, 8'h80, 16'h8000, 1'b1},
    {1'b0, 8'h80, 16'hA000, 1'b0}, {1'b0, 8'h80, 16'h7FFF, 1'b0},
    {1'b0, 8'hE0, 16'hE000, 1'b1}, {1'b1, 8'hC0, 16'hC000, 1'b1},
    {1'b1, 8'hC0, 16'hBFFF, 1'b0}, {1'b1, 8'hC0, 16'hFE00, 1'b1},
    {1'b1, 8'h40, 16'hBFFF, 1'b1}, {1'b1, 8'h40, 16'hC000, 1'b0},
    {1'b1, 8'h90, 16'h9000, 1'b1}, {1'b1, 8'h90, 16'hA000, 1'b0},
    {1'b1, 8'hF1, 16'hA123, 1'b1}, {1'b1, 8'hF1, 16'hF100, 1'b0}
  };

  initial begin
    #600000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    @(negedge clk); #1;
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(oam_we == 1'b0 && src_rd == 1'b0, "R1 strobes after reset", oam_we, 0);
    probe(16'hFE10, 1'b0, "R1 pass-through after reset");

    // R7 / R8 window table (R6 sprite memory rows included)
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][25]);
      start_xfer(VEC[i][24:17], 1'b1);
      probe(VEC[i][16:1], VEC[i][0], VEC[i][25] ? "R8 colour window" : "R7 mono window");
    end

    // R3 R4 R5 full copy, then R11 idle pass-through
    do_reset(1'b1);
    start_xfer(8'hC1, 1'b1);
    wait_done();
    chk(mon_k == LEN, "R3 byte count", mon_k, LEN);
    probe(16'hFE10, 1'b0, "R11 idle sprite access");
    probe(16'hC100, 1'b0, "R11 idle window access");

    // R2 invalid page while idle
    start_xfer(8'hF2, 1'b0);
    repeat (30) @(negedge clk);
    #1 chk(busy == 1'b0, "R2 page above limit ignored", busy, 0);

    // R10 restart mid-copy
    start_xfer(8'hC0, 1'b1);
    wait (mon_k == 3);
    start_xfer(8'hD2, 1'b1);
    wait_done();
    chk(mon_k == LEN, "R10 full count after restart", mon_k, LEN);

    // R2 invalid page mid-copy leaves copy undisturbed
    start_xfer(8'h40, 1'b1);
    wait (mon_k == 5);
    start_xfer(8'hF5, 1'b0);
    wait_done();

    // R9 model held from reset
    do_reset(1'b0);
    @(negedge clk); #1 model_sel = 1'b1;
    start_xfer(8'hC0, 1'b1);
    probe(16'hA000, 1'b1, "R9 model sampled at reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule